// File: doc/BRIEF.md
# Parallel Printer Port Register Controller

This block is the host-side register file of a PC-style parallel printer port. A host reads and writes eight byte-wide offsets. Through them it loads an output byte, drives the four complemented printer control lines, runs the acknowledge/busy handshake that printer drivers poll, and starts enhanced-mode address and data cycles toward a peripheral. The block also raises an interrupt request when a byte is strobed out.

Control writes carry side effects. A write with the init bit clear forces the status register back to its power-on value. A write with select and strobe set, where the old strobe was clear, pushes the data byte out. Status reads advance a small acknowledge/busy sequence. Enhanced-mode cycles are guarded: they run only when the control bits hold one exact pattern, and otherwise they do nothing. The peripheral side of an enhanced cycle is a request/acknowledge pair with a failure flag. A failure latches a timeout bit in status.

Host accesses take one cycle. Read data comes back with a valid pulse on the cycle after the request. An accepted enhanced cycle holds the host busy until the peripheral acknowledges.

Top module: `lpt_port_ctrl`

## Requirements
- R1: After reset, status reads 0xDE (busy 0x80, ack 0x40, online 0x10, error 0x08, with the constant ones at 0x04 and 0x02). Control reads 0xCC (select-in 0x08, init 0x04, bits 7:6 fixed at 1). The pins are pinStrobeN=1, pinAutoFdN=1, pinInitN=0, pinSelInN=0, and irqOut is 0.
- R2: A control write at offset 2 stores bits 5:0: direction 0x20, interrupt enable 0x10, select-in 0x08, init 0x04, autofeed 0x02, strobe 0x01. Each of the four line pins is the inverse of its bit.
- R3: Any control write with init (0x04) clear reloads the stored status to 0xD8. This also clears paper-out and timeout.
- R4: A control write with init, select-in and strobe all set clears busy. It pulses bytePush for one cycle, with pinDataOut holding the data byte, only when the previous strobe bit was 0.
- R5: On a bytePush from a control write with interrupt enable set, irqOut rises in the same cycle. A status read clears it.
- R6: A status read with busy and strobe both 0 steps the handshake. If ack was 1, the read clears it. Otherwise the read sets both ack and busy. The read returns the value from before the step.
- R7: A write to offset 3 (address) or offset 4 (data) starts an enhanced write cycle only when control bits {0x20,0x08,0x04,0x02,0x01} equal 0x04. Otherwise the write has no effect.
- R8: A read of offset 3 or 4 starts an enhanced read cycle only when those bits equal 0x24. Otherwise the read returns 0xFF at once and eppReq stays 0.
- R9: An enhanced cycle holds eppReq, eppWrite and eppAddrCyc steady, and holds hostBusy high, until eppAck. If eppFail is set with the acknowledge, status bit 0x01 is set and a read cycle returns 0xFF.
- R10: A status write (offset 1) with bit 0 set clears the timeout bit. A status write with bit 0 clear leaves it unchanged.
- R11: Offset 0 holds data. It reads back pinDataIn when direction is 1 and the latched byte otherwise. Offsets 5 to 7 read 0xFF and ignore writes. Non-enhanced reads return with hostRdValid one cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostAddr | input | 3 | Register offset |
| hostWrEn | input | 1 | Write request (has priority over read) |
| hostRdEn | input | 1 | Read request |
| hostWrData | input | 8 | Write data |
| hostRdData | output | 8 | Read data |
| hostRdValid | output | 1 | Read data valid pulse |
| hostBusy | output | 1 | Enhanced cycle in flight; accesses ignored |
| irqOut | output | 1 | Interrupt request |
| pinDataOut | output | 8 | Latched output byte |
| pinDataIn | input | 8 | Byte driven by the peripheral |
| pinStrobeN | output | 1 | Strobe line, active low |
| pinAutoFdN | output | 1 | Autofeed line, active low |
| pinInitN | output | 1 | Init line, active low |
| pinSelInN | output | 1 | Select-in line, active low |
| bytePush | output | 1 | One-cycle pulse: byte handed to the printer |
| eppReq | output | 1 | Enhanced cycle request |
| eppAddrCyc | output | 1 | 1 = address cycle, 0 = data cycle |
| eppWrite | output | 1 | 1 = write cycle, 0 = read cycle |
| eppWrData | output | 8 | Byte for an enhanced write |
| eppRdData | input | 8 | Byte returned by an enhanced read |
| eppAck | input | 1 | Peripheral completes the cycle |
| eppFail | input | 1 | Peripheral reports a timeout with eppAck |

## Verification
Some properties are checked on every cycle. A byte push appears only on a strobe rise, and every interrupt rise comes with a push. An enhanced request holds steady until it is acknowledged, and it is only ever seen with the line pattern its direction demands. The timeout bit rises only after a failed acknowledge, and an init-clear write always reloads status. Other behaviour can only be shown by the bench's directed scenarios. These cover the exact stepping order of the acknowledge/busy sequence and the values returned along it, rejected enhanced cycles that leave no trace, the 0xFF fill on rejected or failed reads, and data read-back depending on direction.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  localparam int LPT_DW = 8;
  localparam int LPT_AW = 3;
  localparam int LPT_CW = 6;

  // register offsets
  localparam int OFF_DATA = 0;
  localparam int OFF_STAT = 1;
  localparam int OFF_CTRL = 2;
  localparam int OFF_EADR = 3;
  localparam int OFF_EDAT = 4;

  // control bit indices
  localparam int C_STB = 0;
  localparam int C_AFD = 1;
  localparam int C_INI = 2;
  localparam int C_SEL = 3;
  localparam int C_IEN = 4;
  localparam int C_DIR = 5;

  // status bit indices
  localparam int S_TMO = 0;
  localparam int S_ACK = 6;
  localparam int S_BSY = 7;

  localparam logic [LPT_DW-1:0] STAT_RST  = 8'hD8;
  localparam logic [LPT_DW-1:0] STAT_ONES = 8'h06;
  localparam logic [LPT_DW-1:0] ALL_ONES  = 8'hFF;
  localparam logic [LPT_CW-1:0] CTRL_RST  = 6'h0C;
  localparam logic [LPT_CW-1:0] EPP_MASK  = 6'h2F;
  localparam logic [LPT_CW-1:0] EPP_WPAT  = 6'h04;
  localparam logic [LPT_CW-1:0] EPP_RPAT  = 6'h24;

  typedef struct packed {
    logic              wrData;
    logic              wrStatus;
    logic              wrCtrl;
    logic              rdLocal;
    logic [LPT_AW-1:0] rdSel;
    logic              eppLaunch;
    logic              eppFinish;
    logic              eppFailed;
    logic              eppWasRead;
  } lptCmd_t;
endpackage

// File: rtl/lpt_ctrl.sv
module lpt_ctrl
  import lpt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [LPT_AW-1:0] hostAddr,
  input  logic              hostWrEn,
  input  logic              hostRdEn,
  input  logic [LPT_CW-1:0] ctrlBits,
  input  logic              eppAck,
  input  logic              eppFail,
  output lptCmd_t           cmd,
  output logic              hostBusy,
  output logic              eppReq,
  output logic              eppAddrCyc,
  output logic              eppWrite
);
  typedef enum logic {ST_IDLE, ST_EPP} ctlState_t;

  localparam logic [LPT_AW-1:0] A_DATA = LPT_AW'(OFF_DATA);
  localparam logic [LPT_AW-1:0] A_STAT = LPT_AW'(OFF_STAT);
  localparam logic [LPT_AW-1:0] A_CTRL = LPT_AW'(OFF_CTRL);
  localparam logic [LPT_AW-1:0] A_EADR = LPT_AW'(OFF_EADR);
  localparam logic [LPT_AW-1:0] A_EDAT = LPT_AW'(OFF_EDAT);

  ctlState_t state;
  logic accept, isEpp, wrGo, rdGo, wrPatOk, rdPatOk, launch;

  always_comb begin
    accept  = (state == ST_IDLE);
    isEpp   = (hostAddr == A_EADR) || (hostAddr == A_EDAT);
    wrPatOk = ((ctrlBits & EPP_MASK) == EPP_WPAT);
    rdPatOk = ((ctrlBits & EPP_MASK) == EPP_RPAT);
    wrGo    = accept && hostWrEn;
    rdGo    = accept && hostRdEn && !hostWrEn;
    launch  = (wrGo && isEpp && wrPatOk) || (rdGo && isEpp && rdPatOk);

    cmd            = '0;
    cmd.wrData     = wrGo && (hostAddr == A_DATA);
    cmd.wrStatus   = wrGo && (hostAddr == A_STAT);
    cmd.wrCtrl     = wrGo && (hostAddr == A_CTRL);
    cmd.rdLocal    = rdGo && !(isEpp && rdPatOk);
    cmd.rdSel      = hostAddr;
    cmd.eppLaunch  = launch;
    cmd.eppFinish  = (state == ST_EPP) && eppAck;
    cmd.eppFailed  = (state == ST_EPP) && eppAck && eppFail;
    cmd.eppWasRead = !eppWrite;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      eppAddrCyc <= 1'b0;
      eppWrite   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (launch) begin
          state      <= ST_EPP;
          eppAddrCyc <= (hostAddr == A_EADR);
          eppWrite   <= hostWrEn;
        end
        ST_EPP: if (eppAck) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign hostBusy = (state == ST_EPP);
  assign eppReq   = (state == ST_EPP);
endmodule

// File: rtl/lpt_datapath.sv
module lpt_datapath
  import lpt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  lptCmd_t           cmd,
  input  logic [LPT_DW-1:0] hostWrData,
  input  logic [LPT_DW-1:0] pinDataIn,
  input  logic [LPT_DW-1:0] eppRdData,
  output logic [LPT_CW-1:0] ctrlBits,
  output logic [LPT_DW-1:0] statusBits,
  output logic [LPT_DW-1:0] hostRdData,
  output logic              hostRdValid,
  output logic              irqOut,
  output logic              bytePush,
  output logic [LPT_DW-1:0] pinDataOut,
  output logic [LPT_DW-1:0] eppWrData,
  output logic              pinStrobeN,
  output logic              pinAutoFdN,
  output logic              pinInitN,
  output logic              pinSelInN
);
  logic [LPT_DW-1:0] dataReg, statReg, localRd;
  logic [LPT_CW-1:0] ctrlReg;
  logic              irqPend, stepOk;

  always_comb begin
    case (cmd.rdSel)
      LPT_AW'(OFF_DATA): localRd = ctrlReg[C_DIR] ? pinDataIn : dataReg;
      LPT_AW'(OFF_STAT): localRd = statReg | STAT_ONES;
      LPT_AW'(OFF_CTRL): localRd = {2'b11, ctrlReg};
      default:           localRd = ALL_ONES;
    endcase
    stepOk = !statReg[S_BSY] && !ctrlReg[C_STB];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataReg     <= '0;
      statReg     <= STAT_RST;
      ctrlReg     <= CTRL_RST;
      irqPend     <= 1'b0;
      bytePush    <= 1'b0;
      hostRdValid <= 1'b0;
      hostRdData  <= '0;
      eppWrData   <= '0;
    end else begin
      bytePush    <= 1'b0;
      hostRdValid <= 1'b0;
      if (cmd.wrData) dataReg <= hostWrData;
      if (cmd.wrStatus && hostWrData[S_TMO]) statReg[S_TMO] <= 1'b0;
      if (cmd.wrCtrl) begin
        ctrlReg <= hostWrData[LPT_CW-1:0];
        if (!hostWrData[C_INI]) begin
          statReg <= STAT_RST;
        end else if (hostWrData[C_SEL] && hostWrData[C_STB]) begin
          statReg[S_BSY] <= 1'b0;
          if (!ctrlReg[C_STB]) begin
            bytePush <= 1'b1;
            if (hostWrData[C_IEN]) irqPend <= 1'b1;
          end
        end
      end
      if (cmd.rdLocal) begin
        hostRdValid <= 1'b1;
        hostRdData  <= localRd;
        if (cmd.rdSel == LPT_AW'(OFF_STAT)) begin
          irqPend <= 1'b0;
          if (stepOk) begin
            if (statReg[S_ACK]) statReg[S_ACK] <= 1'b0;
            else begin
              statReg[S_ACK] <= 1'b1;
              statReg[S_BSY] <= 1'b1;
            end
          end
        end
      end
      if (cmd.eppLaunch) eppWrData <= hostWrData;
      if (cmd.eppFinish) begin
        if (cmd.eppFailed) statReg[S_TMO] <= 1'b1;
        if (cmd.eppWasRead) begin
          hostRdValid <= 1'b1;
          hostRdData  <= cmd.eppFailed ? ALL_ONES : eppRdData;
        end
      end
    end
  end

  assign ctrlBits   = ctrlReg;
  assign statusBits = statReg;
  assign irqOut     = irqPend;
  assign pinDataOut = dataReg;
  assign pinStrobeN = ~ctrlReg[C_STB];
  assign pinAutoFdN = ~ctrlReg[C_AFD];
  assign pinInitN   = ~ctrlReg[C_INI];
  assign pinSelInN  = ~ctrlReg[C_SEL];
endmodule

// File: rtl/lpt_port_ctrl.sv
module lpt_port_ctrl
  import lpt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [LPT_AW-1:0] hostAddr,
  input  logic              hostWrEn,
  input  logic              hostRdEn,
  input  logic [LPT_DW-1:0] hostWrData,
  output logic [LPT_DW-1:0] hostRdData,
  output logic              hostRdValid,
  output logic              hostBusy,
  output logic              irqOut,
  output logic [LPT_DW-1:0] pinDataOut,
  input  logic [LPT_DW-1:0] pinDataIn,
  output logic              pinStrobeN,
  output logic              pinAutoFdN,
  output logic              pinInitN,
  output logic              pinSelInN,
  output logic              bytePush,
  output logic              eppReq,
  output logic              eppAddrCyc,
  output logic              eppWrite,
  output logic [LPT_DW-1:0] eppWrData,
  input  logic [LPT_DW-1:0] eppRdData,
  input  logic              eppAck,
  input  logic              eppFail
);
  lptCmd_t           cmd;
  logic [LPT_CW-1:0] ctrlBits;
  logic [LPT_DW-1:0] statusBits;

  lpt_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWrEn(hostWrEn),
    .hostRdEn(hostRdEn), .ctrlBits(ctrlBits), .eppAck(eppAck),
    .eppFail(eppFail), .cmd(cmd), .hostBusy(hostBusy), .eppReq(eppReq),
    .eppAddrCyc(eppAddrCyc), .eppWrite(eppWrite)
  );

  lpt_datapath uDp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .hostWrData(hostWrData),
    .pinDataIn(pinDataIn), .eppRdData(eppRdData), .ctrlBits(ctrlBits),
    .statusBits(statusBits), .hostRdData(hostRdData),
    .hostRdValid(hostRdValid), .irqOut(irqOut), .bytePush(bytePush),
    .pinDataOut(pinDataOut), .eppWrData(eppWrData),
    .pinStrobeN(pinStrobeN), .pinAutoFdN(pinAutoFdN),
    .pinInitN(pinInitN), .pinSelInN(pinSelInN)
  );
endmodule

// File: rtl/lpt_port_chk.sv
module lpt_port_chk
  import lpt_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [LPT_AW-1:0] hostAddr,
  input logic              hostWrEn,
  input logic [LPT_DW-1:0] hostWrData,
  input logic              hostBusy,
  input logic              irqOut,
  input logic              bytePush,
  input logic              pinStrobeN,
  input logic              pinAutoFdN,
  input logic              pinInitN,
  input logic              pinSelInN,
  input logic              eppReq,
  input logic              eppWrite,
  input logic              eppAddrCyc,
  input logic              eppAck,
  input logic              eppFail,
  input logic [LPT_DW-1:0] statusBits
);
  a_r3_init_reload: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && !hostBusy && hostAddr == LPT_AW'(OFF_CTRL) && !hostWrData[C_INI])
      |=> (statusBits == STAT_RST));

  a_r4_push_on_rise: assert property (@(posedge clk) disable iff (!rstN)
    bytePush |-> (!pinStrobeN && $past(pinStrobeN)));

  a_r5_irq_with_push: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> bytePush);

  a_r7_write_pattern: assert property (@(posedge clk) disable iff (!rstN)
    (eppReq && eppWrite) |-> (pinStrobeN && pinAutoFdN && !pinInitN && pinSelInN));

  a_r8_read_pattern: assert property (@(posedge clk) disable iff (!rstN)
    (eppReq && !eppWrite) |-> (pinStrobeN && pinAutoFdN && !pinInitN && pinSelInN));

  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    (eppReq && !eppAck) |=> (eppReq && $stable(eppWrite) && $stable(eppAddrCyc)));

  a_r9_timeout_src: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusBits[S_TMO]) |-> $past(eppReq && eppAck && eppFail));
endmodule

bind lpt_port_ctrl lpt_port_chk uChk (
  .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWrEn(hostWrEn),
  .hostWrData(hostWrData), .hostBusy(hostBusy), .irqOut(irqOut),
  .bytePush(bytePush), .pinStrobeN(pinStrobeN), .pinAutoFdN(pinAutoFdN),
  .pinInitN(pinInitN), .pinSelInN(pinSelInN), .eppReq(eppReq),
  .eppWrite(eppWrite), .eppAddrCyc(eppAddrCyc), .eppAck(eppAck),
  .eppFail(eppFail), .statusBits(statusBits)
);

// File: tb/lpt_port_ctrl_test.sv
`timescale 1ns/1ps
module lpt_port_ctrl_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] hostAddr = '0;
  logic       hostWrEn = 1'b0, hostRdEn = 1'b0;
  logic [7:0] hostWrData = '0;
  logic [7:0] hostRdData;
  logic       hostRdValid, hostBusy, irqOut;
  logic [7:0] pinDataOut;
  logic [7:0] pinDataIn = '0;
  logic       pinStrobeN, pinAutoFdN, pinInitN, pinSelInN, bytePush;
  logic       eppReq, eppAddrCyc, eppWrite;
  logic [7:0] eppWrData;
  logic [7:0] eppRdData = '0;
  logic       eppAck = 1'b0, eppFail = 1'b0;

  int checkCnt = 0;
  int failCnt  = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  lpt_port_ctrl uut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [2:0] a, input logic [7:0] v);
    @(negedge clk); hostAddr = a; hostWrData = v; hostWrEn = 1'b1;
    @(negedge clk); hostWrEn = 1'b0;
  endtask

  task automatic doRead(input logic [2:0] a, output logic [7:0] d, output logic v);
    @(negedge clk); hostAddr = a; hostRdEn = 1'b1;
    @(negedge clk); hostRdEn = 1'b0; d = hostRdData; v = hostRdValid;
  endtask

  task automatic serveEpp(input logic fail, input logic [7:0] d);
    for (int n = 0; n < 20 && !eppReq; n++) @(negedge clk);
    eppAck = 1'b1; eppFail = fail; eppRdData = d;
    @(negedge clk); eppAck = 1'b0; eppFail = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d; logic v;
    chk("R1 strobeN", pinStrobeN, 1); chk("R1 autofdN", pinAutoFdN, 1);
    chk("R1 initN", pinInitN, 0);     chk("R1 selinN", pinSelInN, 0);
    chk("R1 irq", irqOut, 0);
    doRead(3'd1, d, v); chk("R1 status", d, 8'hDE); chk("R11 valid", v, 1);
    doRead(3'd2, d, v); chk("R1 control", d, 8'hCC);
  endtask

  task automatic t_data();
    logic [7:0] d; logic v;
    doWrite(3'd0, 8'hA5);
    chk("R11 pin data", pinDataOut, 8'hA5);
    doWrite(3'd6, 8'h12);
    doRead(3'd6, d, v); chk("R11 unused offset", d, 8'hFF);
    doRead(3'd0, d, v); chk("R11 data readback", d, 8'hA5);
  endtask

  task automatic t_pins();
    logic [7:0] d; logic v;
    doWrite(3'd2, 8'h0A);
    chk("R2 selinN", pinSelInN, 0); chk("R2 initN", pinInitN, 1);
    chk("R2 autofdN", pinAutoFdN, 0); chk("R2 strobeN", pinStrobeN, 1);
    doRead(3'd2, d, v); chk("R2 control read", d, 8'hCA);
    doWrite(3'd2, 8'h0C);
  endtask

  task automatic t_strobe();
    logic [7:0] d; logic v;
    doWrite(3'd2, 8'h05);
    chk("R4 no push without select", bytePush, 0);
    doWrite(3'd2, 8'h0C);
    doWrite(3'd2, 8'h1D);
    chk("R4 push", bytePush, 1); chk("R4 push byte", pinDataOut, 8'hA5);
    chk("R5 irq raised", irqOut, 1);
    @(negedge clk); chk("R4 push one cycle", bytePush, 0);
    doRead(3'd1, d, v); chk("R4 busy cleared", d, 8'h5E);
    chk("R5 irq cleared by status read", irqOut, 0);
    doWrite(3'd2, 8'h1D);
    chk("R4 no push without rise", bytePush, 0);
    chk("R5 no irq without push", irqOut, 0);
  endtask

  task automatic t_handshake();
    logic [7:0] d; logic v;
    doWrite(3'd2, 8'h0C);
    doRead(3'd1, d, v); chk("R6 step1 read", d, 8'h5E);
    doRead(3'd1, d, v); chk("R6 ack cleared", d, 8'h1E);
    doRead(3'd1, d, v); chk("R6 ack busy set", d, 8'hDE);
    doRead(3'd1, d, v); chk("R6 busy holds", d, 8'hDE);
  endtask

  task automatic t_reload();
    logic [7:0] d; logic v;
    doWrite(3'd2, 8'h1D);
    chk("R5 irq again", irqOut, 1);
    doWrite(3'd2, 8'h08);
    doRead(3'd1, d, v); chk("R3 status reload", d, 8'hDE);
  endtask

  task automatic t_eppWrite();
    doWrite(3'd3, 8'h33);
    chk("R7 rejected write no req", eppReq, 0);
    chk("R7 rejected write not busy", hostBusy, 0);
    doWrite(3'd2, 8'h04);
    doWrite(3'd3, 8'h5A);
    chk("R7 addr write req", eppReq, 1); chk("R7 write dir", eppWrite, 1);
    chk("R7 addr cycle", eppAddrCyc, 1); chk("R7 write byte", eppWrData, 8'h5A);
    chk("R9 busy", hostBusy, 1);
    @(negedge clk); @(negedge clk);
    chk("R9 req held", eppReq, 1);
    serveEpp(1'b0, 8'h00);
    chk("R9 req dropped", eppReq, 0);
    doWrite(3'd4, 8'h3C);
    chk("R7 data cycle", eppAddrCyc, 0); chk("R7 data byte", eppWrData, 8'h3C);
    serveEpp(1'b0, 8'h00);
  endtask

  task automatic t_eppRead();
    logic [7:0] d; logic v;
    doRead(3'd4, d, v);
    chk("R8 rejected read 0xFF", d, 8'hFF); chk("R8 rejected valid", v, 1);
    chk("R8 rejected no req", eppReq, 0);
    doWrite(3'd2, 8'h24);
    doRead(3'd4, d, v);
    chk("R8 read pending", v, 0); chk("R8 read req", eppReq, 1);
    chk("R8 read dir", eppWrite, 0);
    serveEpp(1'b0, 8'h96);
    chk("R8 read valid", hostRdValid, 1); chk("R8 read data", hostRdData, 8'h96);
    pinDataIn = 8'h71;
    doRead(3'd0, d, v); chk("R11 input readback", d, 8'h71);
  endtask

  task automatic t_timeout();
    logic [7:0] d; logic v;
    doRead(3'd3, d, v);
    serveEpp(1'b1, 8'h55);
    chk("R9 failed read 0xFF", hostRdData, 8'hFF);
    doRead(3'd1, d, v); chk("R9 timeout set", d[0], 1);
    doWrite(3'd1, 8'h00);
    doRead(3'd1, d, v); chk("R10 timeout kept", d[0], 1);
    doWrite(3'd1, 8'h01);
    doRead(3'd1, d, v); chk("R10 timeout cleared", d[0], 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_data();
    t_pins();
    t_strobe();
    t_handshake();
    t_reload();
    t_eppWrite();
    t_eppRead();
    t_timeout();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checkCnt++; failCnt++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end
endmodule